// File: doc/BRIEF.md
# Two-Element Configurable Glue Logic Cell

The block is a small user-programmed logic cell for joining peripheral signals without external gates or CPU bit-banging. A source bus (UART transmit, event lines, IO pins or any other single-bit signal) feeds two logic elements. Each element picks two sources, looks its output up in a 4-bit truth table and, if asked to, passes that result through a storage stage: an edge-triggered flip-flop, a transparent latch or a set/reset latch. The two tables can also be joined, so that element 0 becomes one 3-input function with an 8-bit table. A typical setting ANDs a UART TX line with a carrier clock to give an infrared-modulated output.

Configuration is written through a narrow register port. Every field can be changed only while the cell is disabled. The one exception is the enable bit, so software can turn the cell off, reprogram it and turn it back on without a glitched mix of old and new settings. Each element's result can be sent to a pin output, to an event output, or to both. All source signals are taken to be synchronous to `clk_i`.

Top module: `clc_glue_cell`

## Requirements
- R1: After reset every configuration field is zero and `pin_o` and `evt_o` are all 0, whatever the sources are.
- R2: In split mode, element i output = table_i[{b,a}], where a = `src_i[sel_a_i]` and b = `src_i[sel_b_i]`, using only bits [3:0] of the table. Register 1 holds sel_a and register 2 holds sel_b, with element 0's field at bit 0 and element 1's field at bit 4. Register 4 is element 0's table and register 5 is element 1's table.
- R3: The truth tables give the listed gates: AND=0x8 (used to gate a TX line with a carrier), NAND=0x7, OR=0xE, NOR=0x1, XOR=0x6, XNOR=0x9 and NOT a=0x5.
- R4: With the merge bit set (CTRL bit 1), element 0 output = table_0[{c,b,a}], where c = `src_i[sel_a_1]`. With the 8-bit table 0xCA this is a 2:1 mux: output is a when c=0 and b when c=1.
- R5: In flip-flop mode (mode code 1), an element captures its LUT result on the `clk_i` edge where its gate source (register 3) is first seen high after being low. The output shows the captured value from the next cycle and holds it until the next such edge.
- R6: In latch mode (mode code 2), the output follows the LUT result while the gate source is high and holds the last value while it is low.
- R7: In set/reset mode (mode code 3), the LUT result sets the element and the gate source resets it. A high reset forces 0 even when set is also high.
- R8: While the enable bit (CTRL bit 0) is low, `pin_o` and `evt_o` are 0 and every storage element is cleared to 0 on the clock, so re-enabling starts from 0.
- R9: While the cell is enabled, register writes change nothing except the enable bit. Mode codes are in register 6, at bits [1:0] for element 0 and [5:4] for element 1; code 0 is combinational.
- R10: `pin_o[i]` carries element i only when CTRL bit 2+i is set. `evt_o[i]` carries element i only when CTRL bit 4+i is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cell clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Selectable source signals |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| pin_o | output | 2 | Element outputs routed to pins |
| evt_o | output | 2 | Element outputs routed to the event bus |

## Verification
The bench builds the cell with the default of eight sources, so that each 3-bit select field can reach every source. Distinct sources can then serve at the same time as LUT inputs, the merged third input and the gate of each element. This allows the flip-flop, latch and set/reset behaviour to be driven from a gate source kept apart from the data sources, and the two elements to be checked side by side with different routing.

// File: rtl/clc_pkg.sv
package clc_pkg;
  localparam int N_EL = 2;
  localparam int AW   = 3;
  localparam int DW   = 8;

  typedef enum logic [1:0] {
    M_COMB = 2'd0,
    M_DFF  = 2'd1,
    M_DLAT = 2'd2,
    M_RSL  = 2'd3
  } seq_mode_e;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_SELA = 3'd1;
  localparam logic [AW-1:0] A_SELB = 3'd2;
  localparam logic [AW-1:0] A_GSEL = 3'd3;
  localparam logic [AW-1:0] A_TT0  = 3'd4;
  localparam logic [AW-1:0] A_TT1  = 3'd5;
  localparam logic [AW-1:0] A_MODE = 3'd6;
endpackage

// File: rtl/clc_cfg_regs.sv
module clc_cfg_regs
  import clc_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic                     en_o,
  output logic                     merge_o,
  output logic [N_EL-1:0]          route_pin_o,
  output logic [N_EL-1:0]          route_evt_o,
  output logic [N_EL-1:0][SW-1:0]  sel_a_o,
  output logic [N_EL-1:0][SW-1:0]  sel_b_o,
  output logic [N_EL-1:0][SW-1:0]  sel_g_o,
  output logic [N_EL-1:0][DW-1:0]  tt_o,
  output logic [N_EL-1:0][1:0]     mode_o
);
  localparam int FSTRIDE = DW / N_EL;

  logic en_q, merge_q;
  logic [N_EL-1:0] rpin_q, revt_q;
  logic [N_EL-1:0][SW-1:0] sa_q, sb_q, sg_q;
  logic [N_EL-1:0][DW-1:0] tt_q;
  logic [N_EL-1:0][1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      merge_q <= 1'b0;
      rpin_q  <= '0;
      revt_q  <= '0;
      sa_q    <= '0;
      sb_q    <= '0;
      sg_q    <= '0;
      tt_q    <= '0;
      mode_q  <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL) en_q <= wdata_i[0];
      // all other fields frozen while running
      if (!en_q) begin
        case (addr_i)
          A_CTRL: begin
            merge_q <= wdata_i[1];
            rpin_q  <= wdata_i[2 +: N_EL];
            revt_q  <= wdata_i[4 +: N_EL];
          end
          A_SELA: for (int i = 0; i < N_EL; i++) sa_q[i] <= wdata_i[i*FSTRIDE +: SW];
          A_SELB: for (int i = 0; i < N_EL; i++) sb_q[i] <= wdata_i[i*FSTRIDE +: SW];
          A_GSEL: for (int i = 0; i < N_EL; i++) sg_q[i] <= wdata_i[i*FSTRIDE +: SW];
          A_TT0:  tt_q[0] <= wdata_i;
          A_TT1:  tt_q[1] <= wdata_i;
          A_MODE: for (int i = 0; i < N_EL; i++) mode_q[i] <= wdata_i[i*FSTRIDE +: 2];
          default: ;
        endcase
      end
    end
  end

  assign en_o        = en_q;
  assign merge_o     = merge_q;
  assign route_pin_o = rpin_q;
  assign route_evt_o = revt_q;
  assign sel_a_o     = sa_q;
  assign sel_b_o     = sb_q;
  assign sel_g_o     = sg_q;
  assign tt_o        = tt_q;
  assign mode_o      = mode_q;

  // R9: configuration stays put while enabled
  a_r9_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> ($stable(tt_q) && $stable(mode_q) && $stable(sa_q) && $stable(sb_q)
              && $stable(sg_q) && $stable(merge_q) && $stable(rpin_q) && $stable(revt_q)));
endmodule

// File: rtl/clc_lut_core.sv
module clc_lut_core
  import clc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int SW    = 3
) (
  input  logic [N_SRC-1:0]         src_i,
  input  logic                     merge_i,
  input  logic [N_EL-1:0][SW-1:0]  sel_a_i,
  input  logic [N_EL-1:0][SW-1:0]  sel_b_i,
  input  logic [N_EL-1:0][SW-1:0]  sel_g_i,
  input  logic [N_EL-1:0][DW-1:0]  tt_i,
  output logic [N_EL-1:0]          lut_o,
  output logic [N_EL-1:0]          gate_o
);
  logic [N_EL-1:0] in_a, in_b;
  logic in_c;

  assign in_c = src_i[sel_a_i[1]];

  for (genvar i = 0; i < N_EL; i++) begin : g_el
    assign in_a[i]   = src_i[sel_a_i[i]];
    assign in_b[i]   = src_i[sel_b_i[i]];
    assign gate_o[i] = src_i[sel_g_i[i]];
    if (i == 0) begin : g_mergeable
      always_comb begin
        if (merge_i) lut_o[i] = tt_i[i][{in_c, in_b[i], in_a[i]}];
        else         lut_o[i] = tt_i[i][{1'b0, in_b[i], in_a[i]}];
      end
    end else begin : g_plain
      assign lut_o[i] = tt_i[i][{1'b0, in_b[i], in_a[i]}];
    end
  end
endmodule

// File: rtl/clc_seq_elem.sv
module clc_seq_elem
  import clc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic       lut_i,
  input  logic       gate_i,
  output logic       out_o
);
  seq_mode_e mode;
  logic q_q, g_q, rise;

  assign mode = seq_mode_e'(mode_i);
  assign rise = gate_i & ~g_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= 1'b0;
      g_q <= 1'b0;
    end else begin
      g_q <= gate_i;
      if (!en_i) q_q <= 1'b0;   // synchronous clear while disabled
      else begin
        case (mode)
          M_DFF:   if (rise) q_q <= lut_i;
          M_DLAT:  if (gate_i) q_q <= lut_i;
          M_RSL:   if (gate_i) q_q <= 1'b0; else if (lut_i) q_q <= 1'b1;
          default: q_q <= 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    case (mode)
      M_DFF:   out_o = q_q;
      M_DLAT:  out_o = gate_i ? lut_i : q_q;
      M_RSL:   out_o = gate_i ? 1'b0 : (lut_i | q_q);
      default: out_o = lut_i;
    endcase
  end

  a_r5_dff_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode == M_DFF && gate_i && !g_q) |=> (q_q == $past(lut_i)));

  a_r6_latch_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode == M_DLAT && gate_i) |=> (q_q == $past(lut_i)));

  a_r7_reset_dominant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode == M_RSL && gate_i && lut_i) |=> !q_q);

  a_r8_clear_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !q_q);
endmodule

// File: rtl/clc_glue_cell.sv
module clc_glue_cell
  import clc_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic [1:0]       pin_o,
  output logic [1:0]       evt_o
);
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic                    en, merge;
  logic [N_EL-1:0]         route_pin, route_evt, lut, gate, el_out;
  logic [N_EL-1:0][SW-1:0] sel_a, sel_b, sel_g;
  logic [N_EL-1:0][DW-1:0] tt;
  logic [N_EL-1:0][1:0]    mode;

  clc_cfg_regs #(.SW(SW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .en_o        (en),
    .merge_o     (merge),
    .route_pin_o (route_pin),
    .route_evt_o (route_evt),
    .sel_a_o     (sel_a),
    .sel_b_o     (sel_b),
    .sel_g_o     (sel_g),
    .tt_o        (tt),
    .mode_o      (mode)
  );

  clc_lut_core #(.N_SRC(N_SRC), .SW(SW)) u_lut (
    .src_i   (src_i),
    .merge_i (merge),
    .sel_a_i (sel_a),
    .sel_b_i (sel_b),
    .sel_g_i (sel_g),
    .tt_i    (tt),
    .lut_o   (lut),
    .gate_o  (gate)
  );

  for (genvar i = 0; i < N_EL; i++) begin : g_seq
    clc_seq_elem u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en),
      .mode_i (mode[i]),
      .lut_i  (lut[i]),
      .gate_i (gate[i]),
      .out_o  (el_out[i])
    );
  end

  assign pin_o = el_out & route_pin & {N_EL{en}};
  assign evt_o = el_out & route_evt & {N_EL{en}};

  a_r8_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (pin_o == '0 && evt_o == '0));

  a_r10_route_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o & ~route_pin) == '0) && ((evt_o & ~route_evt) == '0));
endmodule

// File: tb/tb_clc_glue_cell.sv
module tb_clc_glue_cell;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] src = '0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [1:0] pin, evt;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  clc_glue_cell #(.N_SRC(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .pin_o(pin), .evt_o(evt)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk); src = v; #2;
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk); #2;
  endtask

  // program element 0 (and element 1 mode) from scratch: disable, set, enable
  task automatic setup(input logic [7:0] ctrl, input logic [7:0] sa, input logic [7:0] sb,
                       input logic [7:0] sg, input logic [7:0] t0, input logic [7:0] t1,
                       input logic [7:0] md);
    wr(3'd0, 8'h00);
    wr(3'd1, sa); wr(3'd2, sb); wr(3'd3, sg);
    wr(3'd4, t0); wr(3'd5, t1); wr(3'd6, md);
    wr(3'd0, ctrl & 8'hFE);
    wr(3'd0, ctrl | 8'h01);
  endtask

  task automatic t_reset;
    drive(8'hFF);
    chk("R1 pin after reset", pin, 2'b00);
    chk("R1 evt after reset", evt, 2'b00);
  endtask

  task automatic t_gates;
    logic [3:0] tabs [7];
    tabs = '{4'h8, 4'h7, 4'hE, 4'h1, 4'h6, 4'h9, 4'h5};
    for (int g = 0; g < 7; g++) begin
      // el0: a=src0, b=src1, pin0 routed
      setup(8'h05, 8'h00, 8'h01, 8'h00, {4'h0, tabs[g]}, 8'h00, 8'h00);
      for (int p = 0; p < 4; p++) begin
        drive({6'b0, p[1:0]});
        chk($sformatf("R2/R3 table %h idx %0d", tabs[g], p), pin, {1'b0, tabs[g][p]});
      end
    end
    // IR modulation: TX=src0 gated by carrier src1
    setup(8'h05, 8'h00, 8'h01, 8'h00, 8'h08, 8'h00, 8'h00);
    for (int k = 0; k < 4; k++) begin
      drive({6'b0, k[0], 1'b1});
      chk("R3 carrier passes while tx high", pin, {1'b0, k[0]});
    end
    drive(8'h02);
    chk("R3 carrier blocked while tx low", pin, 2'b00);
  endtask

  task automatic t_merge;
    // a=src0, b=src1, c=el1 sel_a=src2, mux table 0xCA
    setup(8'h07, 8'h20, 8'h01, 8'h00, 8'hCA, 8'h00, 8'h00);
    for (int p = 0; p < 8; p++) begin
      logic a, b, c;
      a = p[0]; b = p[1]; c = p[2];
      drive({5'b0, p[2:0]});
      chk($sformatf("R4 mux idx %0d", p), {1'b0, pin[0]}, {1'b0, c ? b : a});
    end
  endtask

  task automatic t_route;
    // el1: a=src3, b=src4, XOR, event only; el0 table 0xF pin+evt
    setup(8'h15 | 8'h20, 8'h30, 8'h40, 8'h00, 8'h0F, 8'h06, 8'h00);
    drive(8'b0000_1000);
    chk("R10 pin1 unrouted, pin0 routed", pin, 2'b01);
    chk("R10 evt1 routed xor, evt0 routed", evt, 2'b11);
    drive(8'b0001_1000);
    chk("R10 evt1 xor low", evt, 2'b01);
  endtask

  task automatic t_dff;
    // el0 table 0xA (out=a=src0), gate src5, flip-flop
    setup(8'h05, 8'h00, 8'h01, 8'h05, 8'h0A, 8'h00, 8'h01);
    drive(8'h01);
    tick;
    chk("R5 no capture without gate edge", pin, 2'b00);
    drive(8'h21);
    chk("R5 before capturing edge", pin, 2'b00);
    tick;
    chk("R5 captured 1", pin, 2'b01);
    drive(8'h20);
    tick;
    chk("R5 holds while gate stays high", pin, 2'b01);
    drive(8'h00); tick;
    drive(8'h20); tick;
    chk("R5 captured 0 on next edge", pin, 2'b00);
    drive(8'h01); tick;
    drive(8'h21); tick;
    chk("R5 captured 1 again", pin, 2'b01);
  endtask

  task automatic t_disable;
    // continues from t_dff state (holding 1)
    wr(3'd0, 8'h04);
    #2;
    chk("R8 outputs off when disabled", pin, 2'b00);
    wr(3'd0, 8'h05);
    #2;
    chk("R8 storage cleared on re-enable", pin, 2'b00);
  endtask

  task automatic t_dlat;
    setup(8'h05, 8'h00, 8'h01, 8'h05, 8'h0A, 8'h00, 8'h02);
    drive(8'h21);
    chk("R6 transparent high", pin, 2'b01);
    drive(8'h20);
    chk("R6 transparent low", pin, 2'b00);
    drive(8'h21); tick;
    drive(8'h01);
    chk("R6 hold 1 gate low", pin, 2'b01);
    drive(8'h00); tick;
    chk("R6 still 1 after data change", pin, 2'b01);
  endtask

  task automatic t_rs;
    setup(8'h05, 8'h00, 8'h01, 8'h05, 8'h0A, 8'h00, 8'h03);
    drive(8'h00);
    chk("R7 idle 0", pin, 2'b00);
    drive(8'h01);
    chk("R7 set", pin, 2'b01);
    tick;
    drive(8'h00); tick;
    chk("R7 hold after set", pin, 2'b01);
    drive(8'h20);
    chk("R7 reset", pin, 2'b00);
    drive(8'h21);
    chk("R7 reset dominant", pin, 2'b00);
    tick;
    drive(8'h00); tick;
    chk("R7 stays reset", pin, 2'b00);
  endtask

  task automatic t_freeze;
    setup(8'h05, 8'h00, 8'h01, 8'h00, 8'h08, 8'h00, 8'h00);
    wr(3'd4, 8'h0E);
    wr(3'd0, 8'h03);
    wr(3'd6, 8'h01);
    drive(8'h01);
    chk("R9 table write ignored while enabled", pin, 2'b00);
    drive(8'h03);
    chk("R9 still combinational AND", pin, 2'b01);
    drive(8'h02);
    chk("R9 mode write ignored, follows AND", pin, 2'b00);
    wr(3'd0, 8'h04);
    wr(3'd0, 8'h05);
    drive(8'h01);
    chk("R9 table kept after re-enable", pin, 2'b00);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset;
    t_gates;
    t_merge;
    t_route;
    t_dff;
    t_disable;
    t_dlat;
    t_rs;
    t_freeze;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule